// File: doc/BRIEF.md
# Memory Array Address Configurator

This block turns one number, the installed memory size counted in 16 MiB units, into the programming values for up to four memory arrays. The size is cut greedily into power-of-two pieces. Each step takes the lowest set bit of what is left, so small pieces come first. A piece never exceeds 2^8 units. Pieces are placed one after another from address zero. For each piece the block produces a 64-bit array address register value, a configuration byte and a size byte. It also produces a 32-entry DIMM-ID translation table with eight entries per array.

A one-cycle start pulse loads the size and launches a small engine. The engine settles one array per clock cycle. It finishes after four arrays or as soon as nothing remains, whichever comes first, and raises done for exactly one cycle. The outputs then hold until the next start. Boot logic that configures a memory controller uses these values.

Top module: `mem_array_configurator`

## Requirements
- R1: After reset every array register value is zero and done is low. Every configuration byte therefore reads 0x04, every size byte reads 0x00 and every translation entry reads 0x20.
- R2: A start pulse seen while idle captures the size input, clears all four register values and begins a new decomposition from base zero. The size input is not looked at again during that run.
- R3: Each array step uses exponent m. m is the index of the lowest set bit of the remaining size, limited to at most 8. The array then covers 2^m units.
- R4: Array register value i equals base<<24 | (m+1)<<12 | 1<<2 | 1<<0. Here base is the sum of the sizes of arrays 0 to i-1, in units.
- R5: After each array the remaining size drops by 2^m. The run produces at most four arrays and stops as soon as the remaining size is zero. Arrays that are not produced keep the value zero.
- R6: A present array i (register bit 0 set) gives configuration byte 0xF0|i. An absent array gives 0x04.
- R7: Size byte i is 1<<(k-2). Here k is register bits [15:12] minus one, raised to at least 2. An absent array gives 0x00. For example, m=0 gives 0x01, m=3 gives 0x02 and m=8 gives 0x40.
- R8: Translation entry j (0 to 31) belongs to array j/8. If that array is present, the entry's bits from 4 down to 0 are j[4], j[1], j[2], j[3], j[0]. Otherwise the entry is 0x20.
- R9: If the start pulse is captured at clock edge 0 and n arrays are produced, done is high for exactly one cycle, right after edge n+1. All outputs are final at that point.
- R10: A start pulse that arrives while a run is in progress is ignored. The results and the timing of done are those of the run already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to start a decomposition |
| size_i | input | SIZE_W (16) | Total memory size in 16 MiB units |
| done_o | output | 1 | One-cycle pulse when the run has completed |
| arr_reg_o | output | NUM_ARR*64 (256) | Array address register values, array i at bits [64i+63:64i] |
| cfg_o | output | NUM_ARR*8 (32) | Configuration bytes, array i at bits [8i+7:8i] |
| size_o | output | NUM_ARR*8 (32) | Size bytes, array i at bits [8i+7:8i] |
| dimm_o | output | NUM_ARR*8*8 (256) | Translation entries, entry j at bits [8j+7:8j] |

## Verification
On every cycle the assertions check the following. The chosen exponent never skips a set bit of the remaining size and never exceeds the cap. The remaining size only shrinks while arrays are written. The array count stays within four. Done is a lone pulse that comes only once the engine is idle. A start during a run never rewinds the array index. The decoded bytes of absent arrays hold their fixed codes. The exact register values, the placement of each base address, the permuted translation codes and the cycle on which done appears can be shown only by the bench. It sweeps many sizes against an arithmetic model, including sizes that hit the exponent cap and sizes that need more than four pieces.

// File: rtl/macfg_pkg.sv
package macfg_pkg;

  localparam int unsigned REG_W   = 64;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BASE_LSB = 24;
  localparam int unsigned BASE_W  = REG_W - BASE_LSB;

  // Lowest set bit of rem, limited to cap; returns cap when no lower bit is set.
  function automatic logic [3:0] pick_exp(input logic [31:0] rem, input int unsigned cap);
    logic [3:0] e;
    logic       found;
    e     = 4'(cap);
    found = 1'b0;
    for (int b = 0; b < 15; b++) begin
      if (!found && (b < int'(cap)) && rem[b]) begin
        e     = 4'(b);
        found = 1'b1;
      end
    end
    return e;
  endfunction

  // Packs base, exponent and fixed enable bits into an array register value.
  function automatic logic [REG_W-1:0] pack_reg(input logic [BASE_W-1:0] base,
                                                input logic [3:0] e);
    logic [REG_W-1:0] r;
    r        = {base, 24'h0};
    r[15:12] = e + 4'd1;
    r[2]     = 1'b1;
    r[0]     = 1'b1;
    return r;
  endfunction

  // Size byte from the exponent field of a register value.
  function automatic logic [BYTE_W-1:0] size_code(input logic [REG_W-1:0] r);
    logic [3:0] k;
    if (r[15:12] < 4'd3) k = 4'd2;
    else                 k = r[15:12] - 4'd1;
    return BYTE_W'(1) << (k - 4'd2);
  endfunction

  // Bit-permuted translation code for entry index j.
  function automatic logic [BYTE_W-1:0] dimm_code(input logic [4:0] j);
    return {3'b000, j[4], j[1], j[2], j[3], j[0]};
  endfunction

endpackage

// File: rtl/macfg_exp_pick.sv
module macfg_exp_pick
  import macfg_pkg::*;
#(
  parameter int unsigned SIZE_W  = 16,
  parameter int unsigned MAX_EXP = 8
) (
  input  logic [SIZE_W-1:0] rem_i,
  output logic [3:0]        exp_o,
  output logic [SIZE_W-1:0] step_o
);
  always_comb begin
    exp_o  = pick_exp(32'(rem_i), MAX_EXP);
    step_o = SIZE_W'(1) << exp_o;
  end
endmodule

// File: rtl/macfg_seq.sv
module macfg_seq
  import macfg_pkg::*;
#(
  parameter int unsigned SIZE_W  = 16,
  parameter int unsigned NUM_ARR = 4,
  parameter int unsigned IDX_W   = $clog2(NUM_ARR + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [SIZE_W-1:0]       size_i,
  input  logic [3:0]              exp_i,
  input  logic [SIZE_W-1:0]       step_i,
  output logic [SIZE_W-1:0]       rem_o,
  output logic                    busy_o,
  output logic                    wr_en_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    done_o,
  output logic [NUM_ARR*REG_W-1:0] arr_o
);
  logic [SIZE_W-1:0] rem_q, base_q;
  logic              busy_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [REG_W-1:0]  arr_q [NUM_ARR];
  logic              wr_en;

  assign wr_en = busy_q && (rem_q != '0) && (idx_q < IDX_W'(NUM_ARR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      base_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      for (int i = 0; i < int'(NUM_ARR); i++) arr_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          rem_q  <= size_i;
          base_q <= '0;
          idx_q  <= '0;
          for (int i = 0; i < int'(NUM_ARR); i++) arr_q[i] <= '0;
        end
      end else if (wr_en) begin
        for (int i = 0; i < int'(NUM_ARR); i++)
          if (idx_q == IDX_W'(i)) arr_q[i] <= pack_reg(BASE_W'(base_q), exp_i);
        base_q <= base_q + step_i;
        rem_q  <= rem_q - step_i;
        idx_q  <= idx_q + 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign rem_o   = rem_q;
  assign busy_o  = busy_q;
  assign wr_en_o = wr_en;
  assign idx_o   = idx_q;
  assign done_o  = done_q;
  for (genvar g = 0; g < NUM_ARR; g++) begin : g_flat
    assign arr_o[g*REG_W +: REG_W] = arr_q[g];
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_arr_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(NUM_ARR));
  assert_rem_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rem_q < $past(rem_q));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> (idx_q != '0 || !busy_q));
endmodule

// File: rtl/macfg_decode.sv
module macfg_decode
  import macfg_pkg::*;
#(
  parameter int unsigned NUM_ARR      = 4,
  parameter int unsigned DIMM_PER_ARR = 8,
  parameter int unsigned DIMM_N       = NUM_ARR * DIMM_PER_ARR
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_ARR*REG_W-1:0]    arr_i,
  output logic [NUM_ARR*BYTE_W-1:0]   cfg_o,
  output logic [NUM_ARR*BYTE_W-1:0]   size_o,
  output logic [DIMM_N*BYTE_W-1:0]    dimm_o
);
  logic [NUM_ARR-1:0] present;

  for (genvar a = 0; a < NUM_ARR; a++) begin : g_arr
    logic [REG_W-1:0] r;
    assign r          = arr_i[a*REG_W +: REG_W];
    assign present[a] = r[0];
    assign cfg_o[a*BYTE_W +: BYTE_W]  = present[a] ? (8'hF0 | BYTE_W'(a)) : 8'h04;
    assign size_o[a*BYTE_W +: BYTE_W] = present[a] ? size_code(r) : 8'h00;

    assert_absent_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (r == '0) |-> (cfg_o[a*BYTE_W +: BYTE_W] == 8'h04 && size_o[a*BYTE_W +: BYTE_W] == 8'h00));
    assert_size_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      present[a] |-> $onehot(size_o[a*BYTE_W +: BYTE_W]));
  end

  for (genvar j = 0; j < DIMM_N; j++) begin : g_dimm
    assign dimm_o[j*BYTE_W +: BYTE_W] = present[j / DIMM_PER_ARR] ? dimm_code(5'(j)) : 8'h20;
  end
endmodule

// File: rtl/mem_array_configurator.sv
module mem_array_configurator
  import macfg_pkg::*;
#(
  parameter int unsigned SIZE_W       = 16,
  parameter int unsigned NUM_ARR      = 4,
  parameter int unsigned MAX_EXP      = 8,
  parameter int unsigned DIMM_PER_ARR = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic [SIZE_W-1:0]                     size_i,
  output logic                                  done_o,
  output logic [NUM_ARR*64-1:0]                 arr_reg_o,
  output logic [NUM_ARR*8-1:0]                  cfg_o,
  output logic [NUM_ARR*8-1:0]                  size_o,
  output logic [NUM_ARR*DIMM_PER_ARR*8-1:0]     dimm_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_ARR + 1);
  localparam int unsigned DIMM_N = NUM_ARR * DIMM_PER_ARR;

  logic [SIZE_W-1:0] rem, step;
  logic [3:0]        exp_m;
  logic              busy, wr_en;
  logic [IDX_W-1:0]  idx;

  macfg_exp_pick #(.SIZE_W(SIZE_W), .MAX_EXP(MAX_EXP)) u_pick (
    .rem_i(rem), .exp_o(exp_m), .step_o(step)
  );

  macfg_seq #(.SIZE_W(SIZE_W), .NUM_ARR(NUM_ARR), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .exp_i(exp_m), .step_i(step), .rem_o(rem), .busy_o(busy),
    .wr_en_o(wr_en), .idx_o(idx), .done_o(done_o), .arr_o(arr_reg_o)
  );

  macfg_decode #(.NUM_ARR(NUM_ARR), .DIMM_PER_ARR(DIMM_PER_ARR), .DIMM_N(DIMM_N)) u_dec (
    .clk(clk), .rst_n(rst_n), .arr_i(arr_reg_o),
    .cfg_o(cfg_o), .size_o(size_o), .dimm_o(dimm_o)
  );

  assert_exp_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> exp_m <= 4'(MAX_EXP));
  assert_exp_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((rem & (step - 1'b1)) == '0));
  assert_exp_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && exp_m < 4'(MAX_EXP)) |-> rem[exp_m]);
  assert_idx_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && idx < IDX_W'(NUM_ARR)));
endmodule

// File: tb/mem_array_configurator_tb.sv
module mem_array_configurator_tb;
  localparam int NA = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] size_i = '0;
  logic done_o;
  logic [NA*64-1:0] arr_reg_o;
  logic [NA*8-1:0] cfg_o, size_o;
  logic [NA*64-1:0] dimm_o;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mem_array_configurator u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .done_o(done_o), .arr_reg_o(arr_reg_o), .cfg_o(cfg_o),
    .size_o(size_o), .dimm_o(dimm_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_dimm(input int j, input bit pres);
    logic [4:0] v;
    if (!pres) return 8'h20;
    v = 5'(j);
    return 8'(v[0]) + 8'(v[3]) * 2 + 8'(v[2]) * 4 + 8'(v[1]) * 8 + 8'(v[4]) * 16;
  endfunction

  task automatic check_outputs(input logic [63:0] er [NA], input bit pr [NA], input int em [NA]);
    for (int i = 0; i < NA; i++) begin
      logic [63:0] ed;
      chk(arr_reg_o[i*64 +: 64] == er[i], "R4/R5 array register", arr_reg_o[i*64 +: 64], er[i]);
      chk(cfg_o[i*8 +: 8] == (pr[i] ? (8'hF0 | 8'(i)) : 8'h04), "R6 config byte",
          64'(cfg_o[i*8 +: 8]), 64'(pr[i] ? (8'hF0 | 8'(i)) : 8'h04));
      chk(size_o[i*8 +: 8] == (pr[i] ? 8'(1 << ((em[i] < 2 ? 2 : em[i]) - 2)) : 8'h00), "R7 size byte",
          64'(size_o[i*8 +: 8]), 64'(pr[i] ? 8'(1 << ((em[i] < 2 ? 2 : em[i]) - 2)) : 8'h00));
      for (int k = 0; k < 8; k++) ed[k*8 +: 8] = exp_dimm(i*8 + k, pr[i]);
      chk(dimm_o[i*64 +: 64] == ed, "R8 translation entries", dimm_o[i*64 +: 64], ed);
    end
  endtask

  // R2 R3 R9 R10: run one decomposition; optionally pulse start again mid-run.
  task automatic run_case(input logic [15:0] sz, input bit poke);
    logic [63:0] er [NA];
    bit pr [NA];
    int em [NA];
    int rem, base, n, cnt;
    rem = int'(sz); base = 0; n = 0;
    for (int i = 0; i < NA; i++) begin er[i] = '0; pr[i] = 0; em[i] = 0; end
    for (int i = 0; i < NA; i++) begin
      int m;
      if (rem == 0) break;
      m = 0;
      while (m < 8 && ((rem >> m) & 1) == 0) m++;
      er[i] = (64'(base) << 24) + (64'(m + 1) << 12) + 64'd5;
      pr[i] = 1; em[i] = m;
      base += (1 << m); rem -= (1 << m); n++;
    end
    @(negedge clk); start_i = 1'b1; size_i = sz;
    @(negedge clk); start_i = 1'b0;
    cnt = 0;
    while (cnt < 20) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 1) begin start_i = 1'b1; size_i = ~sz; end
      else if (poke && cnt == 2) start_i = 1'b0;
      if (done_o) break;
    end
    start_i = 1'b0;
    chk(cnt == n + 1, poke ? "R10 done timing with start during run" : "R9 done timing",
        64'(cnt), 64'(n + 1));
    check_outputs(er, pr, em);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    begin
      logic [63:0] er [NA];
      bit pr [NA];
      int em [NA];
      for (int i = 0; i < NA; i++) begin er[i] = '0; pr[i] = 0; em[i] = 0; end
      chk(done_o == 1'b0, "R1 done after reset", 64'(done_o), 64'd0);
      check_outputs(er, pr, em);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 600; s++) run_case(16'(s), 1'b0);
    run_case(16'h0300, 1'b0);
    run_case(16'h0100, 1'b0);
    run_case(16'hFFFF, 1'b0);
    run_case(16'h8000, 1'b0);
    run_case(16'h1234, 1'b0);
    run_case(16'h000F, 1'b1);
    run_case(16'h0700, 1'b1);
    run_case(16'h0000, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule